// File: doc/BRIEF.md
# Link Active-State Power Controller

This block follows the power state of the transmit side of a serial link. It has three states: active, a fast standby (L0s) and a deeper standby (L1). It watches a transmit idle flag and a receive idle flag. It counts how long the transmit side has stayed idle and drops into L0s when that time reaches an entry delay. The entry delay is taken from the link partner's advertised L0s exit latency, either in full or divided by four. Once in L0s, a second counter measures how long both directions stay idle. When that time reaches a programmed L1 entry time, the block moves on to L1. Pending transmit work or an explicit wake request brings it back to active at once.

Software reaches three registers through a small write port: a two-bit enable field, the entry-latency select bit and the L1 entry time. Several values are sampled from configuration pins for as long as reset is held, and are then presented read-only as the advertised latencies:
- two L0s exit latencies, one used when the link ends share a reference clock and one used when they do not;
- the clock-mode bit;
- the L1 exit latency;
- the two acceptable latencies.

Top module: `link_aspm_ctrl`

## Requirements
- R1: After reset the enable field is 00b, and the block stays active however long the link is idle. The `link_state` encoding is 0 = active, 1 = L0s, 2 = L1, and code 3 is never produced.
- R2: L0s is entered only from active, only when enable bit 0 is set, and only after E+1 consecutive cycles in which `tx_idle`=1 and `wake_req`=0. `link_state` reads 1 in the cycle after the (E+1)-th such cycle.
- R3: The entry delay E equals `partner_l0s_exit` when the select bit is 0. When the select bit is 1, E is that value shifted right by two. The select bit resets to 0. When E is 0, L0s follows the first idle cycle.
- R4: From L0s, L1 is entered only when enable bit 1 is set, and only after T+1 consecutive L0s cycles with both idle flags at 1 and no wake request. T is the L1 entry time. A cycle with `rx_idle`=0 and `tx_idle`=1 in L0s keeps the block in L0s and restarts that count. L1 is never entered directly from active.
- R5: At reset the L1 entry time loads from `l1_time_init`. Afterwards it can be written through `cfg_addr`=2. `cfg_addr`=0 writes the enable field from `cfg_wdata[1:0]` (bit 0 enables L0s, bit 1 enables L1). `cfg_addr`=1 writes the select bit from `cfg_wdata[0]`. A write to `cfg_addr`=3 changes nothing. A write takes effect from the next cycle.
- R6: `adv_l0s_exit` shows the shared-clock L0s exit latency when the clock-mode bit captured at reset is 1, and the separate-clock value when it is 0.
- R7: The advertised L1 exit latency and both acceptable latencies equal the values captured at reset. All advertised outputs stay unchanged outside reset, whatever is written or driven.
- R8: When `tx_idle`=0 or `wake_req`=1, the block is active in the next cycle, from any state, and the idle count restarts from zero. In L1, `rx_idle`=0 also returns the block to active.
- R9: With enable bit 1 clear, the block stays in L0s for as long as `tx_idle` stays 1 and no wake is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration inputs are sampled while low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 enable field, 1 select bit, 2 L1 entry time, 3 unused |
| cfg_wdata | input | TMR_W | Write data |
| tx_idle | input | 1 | Transmit side has nothing to send |
| rx_idle | input | 1 | Receive side is in standby |
| wake_req | input | 1 | Request to leave standby at once |
| partner_l0s_exit | input | LAT_W | Partner's L0s exit latency, in cycles |
| l1_time_init | input | TMR_W | Reset value of the L1 entry time |
| clk_shared_cfg | input | 1 | Clock-mode bit, 1 when the reference clock is shared |
| l0s_exit_shared_cfg | input | EXL_W | L0s exit latency for a shared clock |
| l0s_exit_sep_cfg | input | EXL_W | L0s exit latency for separate clocks |
| l1_exit_cfg | input | EXL_W | L1 exit latency |
| l0s_accept_cfg | input | EXL_W | Acceptable L0s latency |
| l1_accept_cfg | input | EXL_W | Acceptable L1 latency |
| link_state | output | 2 | Current state: 0 active, 1 L0s, 2 L1 |
| adv_l0s_exit | output | EXL_W | Advertised L0s exit latency |
| adv_l1_exit | output | EXL_W | Advertised L1 exit latency |
| adv_l0s_accept | output | EXL_W | Advertised acceptable L0s latency |
| adv_l1_accept | output | EXL_W | Advertised acceptable L1 latency |

## Verification
The state path is driven by idle runs of exactly E and E+1 cycles, using a full and a quartered partner latency and a quartered latency of zero. These runs separate an off-by-one in either counter from a wrong divide. Runs that are broken by receive activity inside L0s show whether the L1 count truly restarts or only pauses. Wake requests and busy cycles are applied in every state. These tell the exit conditions of L0s apart from those of L1. A second reset with other configuration pins shows whether the advertised latencies and the L1 time come from reset capture rather than from live inputs.

// File: rtl/lpm_pkg.sv
// Shared definitions for the link active-state power controller.
// Assumes: the state code is visible on a 2-bit port with the values below.
package lpm_pkg;
    typedef enum logic [1:0] {
        LS_ACTIVE = 2'd0,
        LS_L0S    = 2'd1,
        LS_L1     = 2'd2
    } lnk_state_e;

    localparam logic [1:0] CFG_ENABLES = 2'd0;
    localparam logic [1:0] CFG_LATSEL  = 2'd1;
    localparam logic [1:0] CFG_L1TIME  = 2'd2;
endpackage

// File: rtl/lpm_idle_counter.sv
// Saturating run-length counter. It counts the cycles in which run is high
// and returns to zero in any cycle in which run is low.
// Assumes: the caller compares the count against a limit of the same width.
module lpm_idle_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    // Count consecutive run cycles, holding at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (!run)           cnt <= '0;
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/lpm_cfg_regs.sv
// Configuration registers. Holds the enable field, the latency select bit
// and the L1 entry time, and captures the reset-time configuration pins.
// Assumes: the configuration pins are valid while rst_n is low.
module lpm_cfg_regs
    import lpm_pkg::*;
#(
    parameter int LAT_W = 6,
    parameter int TMR_W = 8,
    parameter int EXL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [TMR_W-1:0] cfg_wdata,
    input  logic [LAT_W-1:0] partner_l0s_exit,
    input  logic [TMR_W-1:0] l1_time_init,
    input  logic             clk_shared_cfg,
    input  logic [EXL_W-1:0] l0s_exit_shared_cfg,
    input  logic [EXL_W-1:0] l0s_exit_sep_cfg,
    input  logic [EXL_W-1:0] l1_exit_cfg,
    input  logic [EXL_W-1:0] l0s_accept_cfg,
    input  logic [EXL_W-1:0] l1_accept_cfg,
    output logic [1:0]       ctl_q,
    output logic [LAT_W-1:0] entry_lat,
    output logic [TMR_W-1:0] l1_time,
    output logic [EXL_W-1:0] adv_l0s_exit,
    output logic [EXL_W-1:0] adv_l1_exit,
    output logic [EXL_W-1:0] adv_l0s_accept,
    output logic [EXL_W-1:0] adv_l1_accept
);
    localparam int QUARTER_SHIFT = 2;

    logic             lat_sel_q;
    logic             clk_shared_q;
    logic [EXL_W-1:0] l0s_exit_sh_q;
    logic [EXL_W-1:0] l0s_exit_sep_q;

    // Writable registers: defaults on reset, software writes otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q     <= 2'b00;
            lat_sel_q <= 1'b0;
            l1_time   <= l1_time_init;
        end else if (cfg_we) begin
            case (cfg_addr)
                CFG_ENABLES: ctl_q     <= cfg_wdata[1:0];
                CFG_LATSEL:  lat_sel_q <= cfg_wdata[0];
                CFG_L1TIME:  l1_time   <= cfg_wdata;
                default:     ;
            endcase
        end
    end

    // Read-only values: sampled from the pins while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_shared_q   <= clk_shared_cfg;
            l0s_exit_sh_q  <= l0s_exit_shared_cfg;
            l0s_exit_sep_q <= l0s_exit_sep_cfg;
            adv_l1_exit    <= l1_exit_cfg;
            adv_l0s_accept <= l0s_accept_cfg;
            adv_l1_accept  <= l1_accept_cfg;
        end
    end

    // Entry delay: the full partner latency or a quarter of it.
    always_comb begin
        entry_lat = lat_sel_q ? (partner_l0s_exit >> QUARTER_SHIFT) : partner_l0s_exit;
    end

    // Advertised L0s exit latency chosen by the captured clock mode.
    always_comb begin
        adv_l0s_exit = clk_shared_q ? l0s_exit_sh_q : l0s_exit_sep_q;
    end
endmodule

// File: rtl/lpm_state_fsm.sv
// Power state machine: active, L0s and L1. It decides the transitions from
// the idle flags, the enables and the run lengths that the counters report,
// and tells the counters when to run.
// Assumes: the counters clear in any cycle in which their run output is low.
module lpm_state_fsm
    import lpm_pkg::*;
#(
    parameter int LAT_W = 6,
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_idle,
    input  logic             rx_idle,
    input  logic             wake_req,
    input  logic             l0s_en,
    input  logic             l1_en,
    input  logic [LAT_W-1:0] entry_lat,
    input  logic [TMR_W-1:0] l1_time,
    input  logic [LAT_W-1:0] tx_cnt,
    input  logic [TMR_W-1:0] l1_cnt,
    output lnk_state_e       state,
    output logic             tx_run,
    output logic             l1_run
);
    lnk_state_e state_nx;
    logic       tx_leave;

    // Run conditions for the two idle counters.
    always_comb begin
        tx_leave = !tx_idle || wake_req;
        tx_run   = (state == LS_ACTIVE) && !tx_leave;
        l1_run   = (state == LS_L0S) && !tx_leave && rx_idle;
    end

    // Next-state decision.
    always_comb begin
        state_nx = state;
        case (state)
            LS_ACTIVE: if (tx_run && l0s_en && (tx_cnt >= entry_lat)) state_nx = LS_L0S;
            LS_L0S: begin
                if (tx_leave)                                       state_nx = LS_ACTIVE;
                else if (l1_run && l1_en && (l1_cnt >= l1_time))    state_nx = LS_L1;
            end
            LS_L1:   if (tx_leave || !rx_idle) state_nx = LS_ACTIVE;
            default: state_nx = LS_ACTIVE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LS_ACTIVE;
        else        state <= state_nx;
    end
endmodule

// File: rtl/link_aspm_ctrl.sv
// Top of the link active-state power controller. It joins the configuration
// registers, the two idle counters and the state machine.
// Assumes: the idle flags and the wake request are synchronous to clk.
module link_aspm_ctrl
    import lpm_pkg::*;
#(
    parameter int LAT_W = 6,
    parameter int TMR_W = 8,
    parameter int EXL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [TMR_W-1:0] cfg_wdata,
    input  logic             tx_idle,
    input  logic             rx_idle,
    input  logic             wake_req,
    input  logic [LAT_W-1:0] partner_l0s_exit,
    input  logic [TMR_W-1:0] l1_time_init,
    input  logic             clk_shared_cfg,
    input  logic [EXL_W-1:0] l0s_exit_shared_cfg,
    input  logic [EXL_W-1:0] l0s_exit_sep_cfg,
    input  logic [EXL_W-1:0] l1_exit_cfg,
    input  logic [EXL_W-1:0] l0s_accept_cfg,
    input  logic [EXL_W-1:0] l1_accept_cfg,
    output logic [1:0]       link_state,
    output logic [EXL_W-1:0] adv_l0s_exit,
    output logic [EXL_W-1:0] adv_l1_exit,
    output logic [EXL_W-1:0] adv_l0s_accept,
    output logic [EXL_W-1:0] adv_l1_accept
);
    logic [1:0]       ctl_q;
    logic [LAT_W-1:0] entry_lat;
    logic [TMR_W-1:0] l1_time;
    logic [LAT_W-1:0] tx_cnt;
    logic [TMR_W-1:0] l1_cnt;
    logic             tx_run;
    logic             l1_run;
    lnk_state_e       state;

    lpm_cfg_regs #(.LAT_W(LAT_W), .TMR_W(TMR_W), .EXL_W(EXL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .partner_l0s_exit(partner_l0s_exit), .l1_time_init(l1_time_init),
        .clk_shared_cfg(clk_shared_cfg),
        .l0s_exit_shared_cfg(l0s_exit_shared_cfg), .l0s_exit_sep_cfg(l0s_exit_sep_cfg),
        .l1_exit_cfg(l1_exit_cfg), .l0s_accept_cfg(l0s_accept_cfg),
        .l1_accept_cfg(l1_accept_cfg),
        .ctl_q(ctl_q), .entry_lat(entry_lat), .l1_time(l1_time),
        .adv_l0s_exit(adv_l0s_exit), .adv_l1_exit(adv_l1_exit),
        .adv_l0s_accept(adv_l0s_accept), .adv_l1_accept(adv_l1_accept)
    );

    lpm_idle_counter #(.W(LAT_W)) u_tx_cnt (
        .clk(clk), .rst_n(rst_n), .run(tx_run), .cnt(tx_cnt)
    );

    lpm_idle_counter #(.W(TMR_W)) u_l1_cnt (
        .clk(clk), .rst_n(rst_n), .run(l1_run), .cnt(l1_cnt)
    );

    lpm_state_fsm #(.LAT_W(LAT_W), .TMR_W(TMR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .tx_idle(tx_idle), .rx_idle(rx_idle), .wake_req(wake_req),
        .l0s_en(ctl_q[0]), .l1_en(ctl_q[1]),
        .entry_lat(entry_lat), .l1_time(l1_time),
        .tx_cnt(tx_cnt), .l1_cnt(l1_cnt),
        .state(state), .tx_run(tx_run), .l1_run(l1_run)
    );

    // Present the state code on the port.
    always_comb begin
        link_state = state;
    end
endmodule

// File: rtl/lpm_ctrl_checker.sv
// Property checker for the link active-state power controller, bound to the top.
// Assumes: it sees the port signals and the internal enable field.
module lpm_ctrl_checker #(
    parameter int EXL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_idle,
    input logic             rx_idle,
    input logic             wake_req,
    input logic [1:0]       ctl_q,
    input logic [1:0]       link_state,
    input logic [EXL_W-1:0] adv_l0s_exit,
    input logic [EXL_W-1:0] adv_l1_exit,
    input logic [EXL_W-1:0] adv_l0s_accept,
    input logic [EXL_W-1:0] adv_l1_accept
);
    localparam logic [1:0] ST_ACT = 2'd0;
    localparam logic [1:0] ST_L0S = 2'd1;
    localparam logic [1:0] ST_L1  = 2'd2;

    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        link_state != 2'd3); // R1
    AST_L0S_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == ST_ACT && !ctl_q[0]) |=> link_state == ST_ACT); // R2
    AST_NO_L1_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        link_state == ST_ACT |=> link_state != ST_L1); // R4
    AST_L1_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == ST_L0S && !ctl_q[1]) |=> link_state != ST_L1); // R9
    AST_BUSY_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_idle || wake_req) |=> link_state == ST_ACT); // R8
    AST_RX_LEAVES_L1: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == ST_L1 && !rx_idle) |=> link_state == ST_ACT); // R8
    AST_ADV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(adv_l0s_exit) && $stable(adv_l1_exit) &&
                          $stable(adv_l0s_accept) && $stable(adv_l1_accept))); // R7
endmodule

bind link_aspm_ctrl lpm_ctrl_checker #(.EXL_W(EXL_W)) u_lpm_chk (
    .clk(clk), .rst_n(rst_n), .tx_idle(tx_idle), .rx_idle(rx_idle),
    .wake_req(wake_req), .ctl_q(ctl_q), .link_state(link_state),
    .adv_l0s_exit(adv_l0s_exit), .adv_l1_exit(adv_l1_exit),
    .adv_l0s_accept(adv_l0s_accept), .adv_l1_accept(adv_l1_accept)
);

// File: tb/link_aspm_ctrl_bench.sv
// Scoreboard bench: driver tasks queue the expected state code for every
// cycle they drive, and a monitor compares it after the following edge.
module link_aspm_ctrl_bench;
    localparam int LAT_W = 6;
    localparam int TMR_W = 8;
    localparam int EXL_W = 3;
    localparam logic [1:0] ST_ACT = 2'd0;
    localparam logic [1:0] ST_L0S = 2'd1;
    localparam logic [1:0] ST_L1  = 2'd2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_addr = 2'd0;
    logic [TMR_W-1:0] cfg_wdata = '0;
    logic             tx_idle = 1'b0;
    logic             rx_idle = 1'b0;
    logic             wake_req = 1'b0;
    logic [LAT_W-1:0] partner_l0s_exit = 6'd13;
    logic [TMR_W-1:0] l1_time_init = 8'd5;
    logic             clk_shared_cfg = 1'b1;
    logic [EXL_W-1:0] l0s_exit_shared_cfg = 3'd3;
    logic [EXL_W-1:0] l0s_exit_sep_cfg = 3'd6;
    logic [EXL_W-1:0] l1_exit_cfg = 3'd4;
    logic [EXL_W-1:0] l0s_accept_cfg = 3'd2;
    logic [EXL_W-1:0] l1_accept_cfg = 3'd7;
    logic [1:0]       link_state;
    logic [EXL_W-1:0] adv_l0s_exit;
    logic [EXL_W-1:0] adv_l1_exit;
    logic [EXL_W-1:0] adv_l0s_accept;
    logic [EXL_W-1:0] adv_l1_accept;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [1:0] exp_q[$];
    string      tag_q[$];
    logic [1:0] mon_exp;
    string      mon_tag;

    link_aspm_ctrl #(.LAT_W(LAT_W), .TMR_W(TMR_W), .EXL_W(EXL_W)) u_link_aspm_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tx_idle(tx_idle), .rx_idle(rx_idle),
        .wake_req(wake_req), .partner_l0s_exit(partner_l0s_exit),
        .l1_time_init(l1_time_init), .clk_shared_cfg(clk_shared_cfg),
        .l0s_exit_shared_cfg(l0s_exit_shared_cfg), .l0s_exit_sep_cfg(l0s_exit_sep_cfg),
        .l1_exit_cfg(l1_exit_cfg), .l0s_accept_cfg(l0s_accept_cfg),
        .l1_accept_cfg(l1_accept_cfg), .link_state(link_state),
        .adv_l0s_exit(adv_l0s_exit), .adv_l1_exit(adv_l1_exit),
        .adv_l0s_accept(adv_l0s_accept), .adv_l1_accept(adv_l1_accept)
    );

    always #5 clk = ~clk;

    // Monitor: compare the state against the queued expectation after each edge.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() != 0) begin
            mon_exp = exp_q.pop_front();
            mon_tag = tag_q.pop_front();
            checks++;
            if (link_state !== mon_exp) begin
                failures++;
                $display("FAIL %s: link_state actual=%0d expected=%0d", mon_tag, link_state, mon_exp);
            end
        end
    end

    // Driver: set the inputs for one cycle and queue the expected next state.
    task automatic step(input logic ti, input logic ri, input logic wk,
                        input logic [1:0] exp, input string tag);
        @(negedge clk);
        cfg_we = 1'b0;
        tx_idle = ti;
        rx_idle = ri;
        wake_req = wk;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Driver: one register write with the link busy, so the state must be active.
    task automatic cfg_write(input logic [1:0] addr, input logic [TMR_W-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = addr;
        cfg_wdata = data;
        tx_idle = 1'b0;
        rx_idle = 1'b0;
        wake_req = 1'b0;
        exp_q.push_back(ST_ACT);
        tag_q.push_back("R5 write cycle");
    endtask

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_we = 1'b0;
        tx_idle = 1'b0;
        rx_idle = 1'b0;
        wake_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Stimulus.
    initial begin
        do_reset();
        check_val("R1 reset state", int'(link_state), int'(ST_ACT));
        check_val("R6 shared clock latency", int'(adv_l0s_exit), 3);
        check_val("R7 l1 exit", int'(adv_l1_exit), 4);
        check_val("R7 l0s accept", int'(adv_l0s_accept), 2);
        check_val("R7 l1 accept", int'(adv_l1_accept), 7);

        // R1: the enables are clear after reset, so a long idle stays active.
        for (int i = 0; i < 30; i++) step(1, 1, 0, ST_ACT, "R1 disabled idle");

        // R2: L0s only, E = 13.
        cfg_write(2'd0, 8'd1);
        for (int i = 0; i < 14; i++) step(1, 1, 0, (i >= 13) ? ST_L0S : ST_ACT, "R2 entry E=13");
        // R9: with L1 disabled the block stays in L0s.
        for (int i = 0; i < 20; i++) step(1, 1, 0, ST_L0S, "R9 hold in L0s");
        // R8: transmit activity leaves L0s.
        step(0, 1, 0, ST_ACT, "R8 tx busy exit");
        for (int i = 0; i < 14; i++) step(1, 1, 0, (i >= 13) ? ST_L0S : ST_ACT, "R8 count restart");
        step(1, 1, 1, ST_ACT, "R8 wake exit L0s");
        for (int i = 0; i < 20; i++) step(1, 1, 1, ST_ACT, "R8 wake holds active");
        step(1, 1, 0, ST_ACT, "R2 idle run broken at 12");
        for (int i = 0; i < 12; i++) step(1, 1, 0, ST_ACT, "R2 idle run broken at 12");
        step(0, 1, 0, ST_ACT, "R2 idle run broken at 12");

        // R3: quarter select, E = 13 >> 2 = 3.
        cfg_write(2'd1, 8'd1);
        for (int i = 0; i < 4; i++) step(1, 1, 0, (i >= 3) ? ST_L0S : ST_ACT, "R3 quarter E=3");

        // R4: both enables set, T = 5 from reset.
        cfg_write(2'd0, 8'd3);
        for (int i = 0; i < 4; i++) step(1, 1, 0, (i >= 3) ? ST_L0S : ST_ACT, "R4 reach L0s");
        for (int j = 0; j < 6; j++) step(1, 1, 0, (j >= 5) ? ST_L1 : ST_L0S, "R4 L1 entry T=5");
        for (int j = 0; j < 3; j++) step(1, 1, 0, ST_L1, "R4 hold L1");
        step(1, 0, 0, ST_ACT, "R8 rx activity leaves L1");
        // R4: receive activity in L0s restarts the L1 count.
        for (int i = 0; i < 4; i++) step(1, 1, 0, (i >= 3) ? ST_L0S : ST_ACT, "R4 reach L0s");
        for (int j = 0; j < 3; j++) step(1, 1, 0, ST_L0S, "R4 partial count");
        step(1, 0, 0, ST_L0S, "R4 rx busy stays in L0s");
        for (int j = 0; j < 6; j++) step(1, 1, 0, (j >= 5) ? ST_L1 : ST_L0S, "R4 count restarted");
        step(1, 1, 1, ST_ACT, "R8 wake exit L1");

        // R5: write T = 2; a write to address 3 is ignored.
        cfg_write(2'd2, 8'd2);
        cfg_write(2'd3, 8'd0);
        for (int i = 0; i < 4; i++) step(1, 1, 0, (i >= 3) ? ST_L0S : ST_ACT, "R5 reach L0s");
        for (int j = 0; j < 3; j++) step(1, 1, 0, (j >= 2) ? ST_L1 : ST_L0S, "R5 written T=2");
        step(0, 1, 0, ST_ACT, "R8 tx busy exit L1");
        @(negedge clk);
        @(negedge clk);
        check_val("R7 l0s exit unchanged", int'(adv_l0s_exit), 3);
        check_val("R7 l1 exit unchanged", int'(adv_l1_exit), 4);
        check_val("R7 accept unchanged", int'(adv_l1_accept), 7);

        // Second reset: separate clocks, T init 1, partner latency 2.
        partner_l0s_exit = 6'd2;
        l1_time_init = 8'd1;
        clk_shared_cfg = 1'b0;
        l1_exit_cfg = 3'd1;
        l0s_accept_cfg = 3'd5;
        l1_accept_cfg = 3'd0;
        do_reset();
        check_val("R6 separate clock latency", int'(adv_l0s_exit), 6);
        check_val("R7 l1 exit recaptured", int'(adv_l1_exit), 1);
        check_val("R7 l0s accept recaptured", int'(adv_l0s_accept), 5);
        check_val("R7 l1 accept recaptured", int'(adv_l1_accept), 0);
        for (int i = 0; i < 10; i++) step(1, 1, 0, ST_ACT, "R1 enables reset again");
        cfg_write(2'd0, 8'd3);
        for (int i = 0; i < 3; i++) step(1, 1, 0, (i >= 2) ? ST_L0S : ST_ACT, "R3 select reset to full E=2");
        for (int j = 0; j < 2; j++) step(1, 1, 0, (j >= 1) ? ST_L1 : ST_L0S, "R5 init T=1");
        // R3: E = 2 >> 2 = 0, L0s after the first idle cycle.
        cfg_write(2'd1, 8'd1);
        step(1, 1, 0, ST_L0S, "R3 zero entry delay");
        clk_shared_cfg = 1'b1;
        l1_exit_cfg = 3'd6;
        step(1, 1, 0, ST_L0S, "R6 live pin ignored");
        @(negedge clk);
        @(negedge clk);
        check_val("R6 live pin ignored", int'(adv_l0s_exit), 6);
        check_val("R7 live pin ignored", int'(adv_l1_exit), 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule